// File: doc/BRIEF.md
# DRAM Refresh and Initialization Sequencer

This block keeps an asynchronous DRAM array alive. When reset is released it waits out the power-up pause. It then runs a fixed burst of wake-up refresh cycles, and only after that does it raise `ready` to tell the access controller that normal traffic may begin. From then on an interval timer asks for one refresh per slot. A slot is the full refresh period divided by the number of rows, for example 64 ms / 4096 rows, or about 15.6 µs. Slots that cannot be served at once are held in a small saturating backlog counter.

The sequencer shares the strobe pins with the access controller through a request/grant handshake. It raises `rfsh_req` while work is pending. The access controller finishes its own cycle, stops starting new host cycles and answers with `rfsh_gnt`. While `bus_own` is high the sequencer drives RAS, CAS and W, and the outside mux must pass its strobes to the array. The default refresh is CAS-before-RAS with W held high, so the address and data pins are not used. A parameter selects a RAS-only variant instead. In that variant CAS stays high and an internal row counter, which wraps at the row count, supplies the row address.

All durations are parameters counted in clock cycles: the pause, the number of wake-up cycles, the refresh interval, the CAS-to-RAS setup, the RAS low width, the CAS hold after RAS, and the precharge.

Top module: `dram_refresh_seq`

## Requirements
- R1: In reset and for the first PAUSE_CYC cycles after the reset synchronizer releases, RAS, CAS and W stay high, `ready`, `rfsh_req` and `bus_own` stay low. The first strobe falls exactly PAUSE_CYC cycles after the synchronized release.
- R2: Right after the pause, exactly WAKE_CNT refresh cycles run back to back, each T_CSR+T_RAS+T_RP cycles long, with no grant needed. `ready` rises in the cycle that follows the last one.
- R3: `ready` is low until initialization completes and then never falls again. `rfsh_req` is never high while `ready` is low.
- R4: In CAS-before-RAS mode, CAS is low with RAS still high for exactly T_CSR cycles before RAS falls.
- R5: RAS stays low for exactly T_RAS cycles. In CAS-before-RAS mode, CAS stays low for the first T_CHR of those cycles and is high again before RAS rises.
- R6: Between the rise of RAS and the next falling strobe, both RAS and CAS are high for at least T_RP cycles.
- R7: W (`we_n`) is high in every cycle.
- R8: The first refresh request appears INTERVAL_CYC cycles after `ready` rises. While the grant is held, one refresh cycle is completed per interval.
- R9: After initialization no refresh cycle starts without `rfsh_gnt` in the preceding cycle. `rfsh_req` stays high while work is pending and the grant is withheld.
- R10: The backlog counts at most PEND_MAX missed slots. Further slots are dropped. When the grant returns, exactly the stored number of cycles run, separated by one idle cycle each, and `rfsh_req` then falls.
- R11: A refresh cycle that has started runs to its end with full timing, even if `rfsh_gnt` falls during it.
- R12: With ROW_ONLY=1, CAS stays high at all times. `row_addr` is valid while RAS is low and equals the number of completed refresh cycles modulo ROWS, so it wraps from ROWS-1 to 0.
- R13: `bus_own` is high exactly in the setup, RAS-low and precharge cycles of a refresh, so it covers every cycle in which RAS is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released internally through a two-stage synchronizer |
| rfsh_gnt | input | 1 | Access controller has freed the strobes for a refresh |
| rfsh_req | output | 1 | Refresh work is pending and the sequencer is idle |
| bus_own | output | 1 | Sequencer is driving the DRAM strobes |
| ready | output | 1 | Initialization done, host accesses allowed |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low, held high |
| row_addr | output | $clog2(ROWS) | Refresh row in RAS-only mode, zero otherwise |

## Verification
The hardest state to reach is a saturated backlog that meets a returning grant. The grant has to be withheld across more interval slots than the counter can hold, and released just after a slot boundary, so that the drain is not mixed with a fresh request. The bench withdraws the grant right after a refresh has completed, keeps it low for five slots against a bound of three, and releases it one cycle after the fifth tick. It then counts the refresh cycles that follow. The bench also drops the grant in the middle of a later refresh cycle, and the per-cycle timing monitor shows that this cycle still ends with full widths.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_IDLE,
    ST_SETUP,
    ST_ACT,
    ST_PRE
  } seq_state_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rfsh_interval.sv
module rfsh_interval #(
  parameter int INTERVAL_CYC = 780
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int TW = $clog2(INTERVAL_CYC);
  localparam logic [TW-1:0] RELOAD = TW'(INTERVAL_CYC - 1);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = en && (cnt_q == '0);
    cnt_d = cnt_q;
    if (!en)       cnt_d = RELOAD;
    else if (tick) cnt_d = RELOAD;
    else           cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= RELOAD;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rfsh_backlog.sv
module rfsh_backlog #(
  parameter int PEND_MAX = 7
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          inc,
  input  logic                          dec,
  output logic [$clog2(PEND_MAX+1)-1:0] cnt,
  output logic                          nz
);
  localparam int PW = $clog2(PEND_MAX + 1);
  localparam logic [PW-1:0] TOP = PW'(PEND_MAX);

  logic [PW-1:0] cnt_q, cnt_d;
  logic          upd;

  always_comb begin
    cnt_d = cnt_q;
    upd   = 1'b0;
    unique case ({inc, dec && (cnt_q != '0)})
      2'b10: if (cnt_q != TOP) begin cnt_d = cnt_q + 1'b1; upd = 1'b1; end
      2'b01: begin cnt_d = cnt_q - 1'b1; upd = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (upd) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
  assign nz  = (cnt_q != '0);
endmodule

// File: rtl/rfsh_row_ctr.sv
module rfsh_row_ctr #(
  parameter int ROWS = 4096
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    adv,
  output logic [$clog2(ROWS)-1:0] row
);
  localparam int RW = $clog2(ROWS);
  localparam logic [RW-1:0] LAST = RW'(ROWS - 1);

  logic [RW-1:0] row_q, row_d;

  always_comb begin
    row_d = (row_q == LAST) ? '0 : row_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   row_q <= '0;
    else if (adv) row_q <= row_d;
  end

  assign row = row_q;
endmodule

// File: rtl/rfsh_engine.sv
module rfsh_engine
  import rfsh_pkg::*;
#(
  parameter int PAUSE_CYC = 10000,
  parameter int WAKE_CNT  = 8,
  parameter int T_CSR     = 1,
  parameter int T_RAS     = 3,
  parameter int T_CHR     = 1,
  parameter int T_RP      = 2,
  parameter int ROW_ONLY  = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pend_nz,
  input  logic gnt,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic bus_own,
  output logic idle,
  output logic ready,
  output logic cyc_done
);
  localparam int MAXC = imax(imax(PAUSE_CYC, T_CSR), imax(T_RAS, T_RP));
  localparam int CW   = $clog2(MAXC) + 1;
  localparam int WW   = $clog2(WAKE_CNT + 1);
  localparam logic [CW-1:0] L_PAUSE = CW'(PAUSE_CYC - 1);
  localparam logic [CW-1:0] L_CSR   = CW'(T_CSR - 1);
  localparam logic [CW-1:0] L_RAS   = CW'(T_RAS - 1);
  localparam logic [CW-1:0] L_RP    = CW'(T_RP - 1);
  localparam logic [CW-1:0] HOLD_TH = CW'(T_RAS - T_CHR);

  seq_state_e    st_q, st_d;
  logic [CW-1:0] ph_q, ph_d;
  logic [WW-1:0] wk_q, wk_d;
  logic          init_q, init_d;
  logic          ph_end;

  assign ph_end = (ph_q == '0);

  // next-state process
  always_comb begin
    st_d   = st_q;
    ph_d   = ph_end ? ph_q : ph_q - 1'b1;
    wk_d   = wk_q;
    init_d = init_q;
    unique case (st_q)
      ST_PAUSE: if (ph_end) begin st_d = ST_SETUP; ph_d = L_CSR; end
      ST_IDLE:  if (pend_nz && gnt) begin st_d = ST_SETUP; ph_d = L_CSR; end
      ST_SETUP: if (ph_end) begin st_d = ST_ACT; ph_d = L_RAS; end
      ST_ACT:   if (ph_end) begin st_d = ST_PRE; ph_d = L_RP; end
      ST_PRE: begin
        if (ph_end) begin
          if (!init_q) begin
            wk_d = wk_q - 1'b1;
            if (wk_q == WW'(1)) begin
              st_d   = ST_IDLE;
              init_d = 1'b1;
            end else begin
              st_d = ST_SETUP;
              ph_d = L_CSR;
            end
          end else begin
            st_d = ST_IDLE;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_PAUSE;
      ph_q   <= L_PAUSE;
      wk_q   <= WW'(WAKE_CNT);
      init_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      wk_q   <= wk_d;
      init_q <= init_d;
    end
  end

  logic cas_low_cbr;
  assign cas_low_cbr = (st_q == ST_SETUP) || ((st_q == ST_ACT) && (ph_q >= HOLD_TH));

  generate
    if (ROW_ONLY != 0) begin : g_row_only
      assign cas_n = cas_low_cbr ? 1'b1 : 1'b1;
    end else begin : g_cbr
      assign cas_n = !cas_low_cbr;
    end
  endgenerate

  assign ras_n    = (st_q != ST_ACT);
  assign we_n     = 1'b1;
  assign bus_own  = (st_q == ST_SETUP) || (st_q == ST_ACT) || (st_q == ST_PRE);
  assign idle     = (st_q == ST_IDLE);
  assign ready    = init_q;
  assign cyc_done = (st_q == ST_PRE) && ph_end;
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
  parameter int PAUSE_CYC    = 10000,
  parameter int WAKE_CNT     = 8,
  parameter int INTERVAL_CYC = 780,
  parameter int PEND_MAX     = 7,
  parameter int T_CSR        = 1,
  parameter int T_RAS        = 3,
  parameter int T_CHR        = 1,
  parameter int T_RP         = 2,
  parameter int ROW_ONLY     = 0,
  parameter int ROWS         = 4096
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rfsh_gnt,
  output logic                    rfsh_req,
  output logic                    bus_own,
  output logic                    ready,
  output logic                    ras_n,
  output logic                    cas_n,
  output logic                    we_n,
  output logic [$clog2(ROWS)-1:0] row_addr
);
  localparam int PW = $clog2(PEND_MAX + 1);

  // asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic          tick, pend_nz, eng_idle, cyc_done, svc_done;
  logic [PW-1:0] pend_cnt;

  rfsh_interval #(.INTERVAL_CYC(INTERVAL_CYC)) u_interval (
    .clk(clk), .rst_n(rst_sync_n), .en(ready), .tick(tick)
  );

  // a completion during init (ready still low) is not a serviced slot
  assign svc_done = cyc_done && ready;

  rfsh_backlog #(.PEND_MAX(PEND_MAX)) u_backlog (
    .clk(clk), .rst_n(rst_sync_n), .inc(tick), .dec(svc_done),
    .cnt(pend_cnt), .nz(pend_nz)
  );

  rfsh_engine #(
    .PAUSE_CYC(PAUSE_CYC), .WAKE_CNT(WAKE_CNT), .T_CSR(T_CSR), .T_RAS(T_RAS),
    .T_CHR(T_CHR), .T_RP(T_RP), .ROW_ONLY(ROW_ONLY)
  ) u_engine (
    .clk(clk), .rst_n(rst_sync_n), .pend_nz(pend_nz), .gnt(rfsh_gnt),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .bus_own(bus_own),
    .idle(eng_idle), .ready(ready), .cyc_done(cyc_done)
  );

  generate
    if (ROW_ONLY != 0) begin : g_rows
      rfsh_row_ctr #(.ROWS(ROWS)) u_row (
        .clk(clk), .rst_n(rst_sync_n), .adv(cyc_done), .row(row_addr)
      );
    end else begin : g_norows
      assign row_addr = '0;
    end
  endgenerate

  assign rfsh_req = ready && pend_nz && eng_idle;
endmodule

// File: rtl/rfsh_seq_chk.sv
module rfsh_seq_chk #(
  parameter int ROW_ONLY = 0,
  parameter int ROWS     = 4096,
  parameter int PEND_MAX = 7
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          rfsh_gnt,
  input logic                          rfsh_req,
  input logic                          bus_own,
  input logic                          ready,
  input logic                          ras_n,
  input logic                          cas_n,
  input logic [$clog2(ROWS)-1:0]       row_addr,
  input logic [$clog2(PEND_MAX+1)-1:0] pend_cnt
);
  a_r3_req_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_req |-> ready);

  a_r3_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  a_r9_start_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_own) && ready) |-> $past(rfsh_gnt));

  a_r13_ras_low_owned: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> bus_own);

  a_r10_backlog_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pend_cnt) <= PEND_MAX);

  generate
    if (ROW_ONLY != 0) begin : g_ror
      a_r12_cas_stays_high: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> cas_n);
      a_r12_row_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(row_addr) < ROWS);
    end else begin : g_cbr
      a_r4_cas_leads_ras: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (!cas_n && $past(!cas_n)));
    end
  endgenerate
endmodule

bind dram_refresh_seq rfsh_seq_chk #(
  .ROW_ONLY(ROW_ONLY), .ROWS(ROWS), .PEND_MAX(PEND_MAX)
) chk_i (
  .clk(clk), .rst_n(rst_n), .rfsh_gnt(rfsh_gnt), .rfsh_req(rfsh_req),
  .bus_own(bus_own), .ready(ready), .ras_n(ras_n), .cas_n(cas_n),
  .row_addr(row_addr), .pend_cnt(pend_cnt)
);

// File: tb/dram_refresh_seq_tb_top.sv
`timescale 1ns/1ps
module dram_refresh_seq_tb_top;
  localparam int PAUSE = 20, WAKE = 8, INTV = 40, PMAX = 3;
  localparam int CSR = 2, RASW = 4, CHR = 2, RP = 3;
  localparam int ROWS_C = 8, ROWS_R = 6;
  localparam int OFS  = 2;                 // reset synchronizer depth
  localparam int L    = CSR + RASW + RP;   // one refresh cycle
  localparam int T0   = OFS + PAUSE;       // first strobe fall
  localparam int TRDY = T0 + WAKE * L;     // ready rises
  localparam int T_LOW = TRDY + INTV * 11 + 18;
  localparam int T_UP  = TRDY + INTV * 16;

  logic clk = 1'b0;
  logic rst_n, gnt;
  always #10 clk = ~clk;   // 50 MHz

  logic req, own, rdy, ras_n, cas_n, we_n;
  logic [$clog2(ROWS_C)-1:0] row_c;
  logic r_req, r_own, r_rdy, r_ras, r_cas, r_we;
  logic [$clog2(ROWS_R)-1:0] row_r;

  dram_refresh_seq #(
    .PAUSE_CYC(PAUSE), .WAKE_CNT(WAKE), .INTERVAL_CYC(INTV), .PEND_MAX(PMAX),
    .T_CSR(CSR), .T_RAS(RASW), .T_CHR(CHR), .T_RP(RP), .ROW_ONLY(0), .ROWS(ROWS_C)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .rfsh_gnt(gnt), .rfsh_req(req), .bus_own(own),
    .ready(rdy), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .row_addr(row_c)
  );

  dram_refresh_seq #(
    .PAUSE_CYC(PAUSE), .WAKE_CNT(WAKE), .INTERVAL_CYC(INTV), .PEND_MAX(PMAX),
    .T_CSR(CSR), .T_RAS(RASW), .T_CHR(CHR), .T_RP(RP), .ROW_ONLY(1), .ROWS(ROWS_R)
  ) dut_ror_i (
    .clk(clk), .rst_n(rst_n), .rfsh_gnt(gnt), .rfsh_req(r_req), .bus_own(r_own),
    .ready(r_rdy), .ras_n(r_ras), .cas_n(r_cas), .we_n(r_we), .row_addr(row_r)
  );

  int tests = 0, fails = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor state
  int cyc, nref, own_cyc, lead, rlow, chr, gap, ready_cyc, req_cyc;
  int we_bad, req_early, ready_drop, own_bad, row_bad_c;
  int nref_r, r_cas_low;
  bit first_cas, p_ras, p_cas, pr_ras;

  always @(negedge clk) begin
    if (!rst_n) begin
      cyc = 0; nref = 0; own_cyc = 0; lead = 0; rlow = 0; chr = 0; gap = 0;
      ready_cyc = -1; req_cyc = -1; we_bad = 0; req_early = 0; ready_drop = 0;
      own_bad = 0; row_bad_c = 0; nref_r = 0; r_cas_low = 0;
      first_cas = 1'b1; p_ras = 1'b1; p_cas = 1'b1; pr_ras = 1'b1;
    end else begin
      cyc++;
      if (p_cas && !cas_n) begin
        if (first_cas) begin
          chk(cyc == T0, "R1 first strobe after pause", cyc, T0);
          first_cas = 1'b0;
        end else begin
          chk(gap >= RP, "R6 precharge gap", gap, RP);
        end
        gap = 0;
      end
      if (p_ras && !ras_n) begin
        chk(lead == CSR, "R4 cas lead before ras", lead, CSR);
        lead = 0; chr = 0; rlow = 0;
      end
      if (!p_ras && ras_n) begin
        chk(rlow == RASW, "R5 ras low width", rlow, RASW);
        chk(chr == CHR, "R5 cas hold after ras", chr, CHR);
        nref++;
      end
      if (!cas_n && ras_n) lead++;
      if (!ras_n) rlow++;
      if (!ras_n && !cas_n) chr++;
      if (ras_n && cas_n) gap++;
      if (own) own_cyc++;
      if (!we_n || !r_we) we_bad++;
      if (!rdy && req) req_early++;
      if (rdy && ready_cyc < 0) ready_cyc = cyc;
      if (!rdy && ready_cyc >= 0) ready_drop++;
      if (req && req_cyc < 0) req_cyc = cyc;
      if (!ras_n && !own) own_bad++;
      if (row_c != '0) row_bad_c++;
      // row-only instance
      if (pr_ras && !r_ras) begin
        chk(r_cas == 1'b1, "R12 cas high at ras fall", r_cas, 1);
        chk(int'(row_r) == nref_r % ROWS_R, "R12 row address", row_r, nref_r % ROWS_R);
      end
      if (!pr_ras && r_ras) nref_r++;
      if (!r_cas) r_cas_low++;
      p_ras = ras_n; p_cas = cas_n; pr_ras = r_ras;
    end
  end

  task automatic wait_cyc(input int k);
    while (cyc < k) begin
      @(negedge clk); #1;
    end
  endtask

  int n_low, n_mid;

  initial begin
    rst_n = 1'b0; gnt = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk(ras_n && cas_n && we_n, "R1 strobes high in reset", {ras_n, cas_n, we_n}, 7);
    chk(!rdy && !req && !own, "R1 status low in reset", {rdy, req, own}, 0);
    chk(r_ras && r_cas, "R1 row-only strobes high in reset", {r_ras, r_cas}, 3);
    @(negedge clk); #1 rst_n = 1'b1;

    wait_cyc(T0 - 1);
    chk(ras_n && cas_n && !own, "R1 idle through pause", {ras_n, cas_n, own}, 6);

    wait_cyc(TRDY);
    chk(ready_cyc == TRDY, "R2 ready rise cycle", ready_cyc, TRDY);
    chk(nref == WAKE, "R2 wake-up cycles without grant", nref, WAKE);
    chk(own_cyc == WAKE * L, "R13 ownership during init", own_cyc, WAKE * L);
    chk(req_early == 0, "R3 no request before ready", req_early, 0);
    chk(nref_r == WAKE, "R12 row-only wake-up count", nref_r, WAKE);
    gnt = 1'b1;

    wait_cyc(TRDY + INTV * 10 + 20);
    chk(req_cyc == TRDY + INTV, "R8 first request", req_cyc, TRDY + INTV);
    chk(nref == WAKE + 10, "R8 one refresh per interval", nref, WAKE + 10);
    chk(own_cyc == (WAKE + 10) * L, "R13 ownership per refresh", own_cyc, (WAKE + 10) * L);

    wait_cyc(T_LOW);
    n_low = nref;
    gnt = 1'b0;
    wait_cyc(T_UP);
    chk(nref == n_low, "R9 nothing starts without grant", nref, n_low);
    chk(req == 1'b1, "R9 request held while pending", req, 1);
    gnt = 1'b1;

    wait_cyc(T_UP + 33);
    chk(nref == n_low + PMAX, "R10 backlog drained to bound", nref - n_low, PMAX);
    chk(req == 1'b0, "R10 request drops after drain", req, 0);

    n_mid = nref;
    wait_cyc(T_UP + 44);
    chk(!ras_n, "R11 cycle in progress at grant drop", ras_n, 0);
    gnt = 1'b0;
    wait_cyc(T_UP + 58);
    chk(nref == n_mid + 1, "R11 started cycle completes", nref - n_mid, 1);
    gnt = 1'b1;

    wait_cyc(T_UP + 110);
    chk(nref == n_mid + 2, "R8 service resumes", nref - n_mid, 2);
    chk(we_bad == 0, "R7 write enable high", we_bad, 0);
    chk(ready_drop == 0, "R3 ready stays high", ready_drop, 0);
    chk(own_bad == 0, "R13 ras low only while owned", own_bad, 0);
    chk(r_cas_low == 0, "R12 cas never low in row-only mode", r_cas_low, 0);
    chk(nref_r == nref, "R12 row-only refresh count", nref_r, nref);
    chk(row_bad_c == 0, "R12 row address zero in cbr mode", row_bad_c, 0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog expired at cycle %0d expected end by %0d", cyc, T_UP + 110);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule